// File: doc/BRIEF.md
# Page-Mode DRAM Access Sequencer

This block turns requests from two masters into page-mode DRAM strobe sequences. A single-word port serves a processor: one read or write, acknowledged with a one-clock strobe. A burst port serves a display fetch engine. It reads a run of consecutive words starting at a given address, and marks each word with a valid strobe and the final word with a last flag. The block drives the active-low row strobe, column strobe and write strobe, plus a multiplexed address bus that carries the row first and the column second.

Configuration arrives as static inputs:
- an overall enable
- an idle-time refresh style
- a 2-bit spacing code for later burst words
- an extended-data-out (EDO) select that shortens burst words
- a 2-bit page length
- a slow-multiplex option that inserts one extra clock after the row phase

Consecutive burst words that fall in the same page skip the row phase. When a burst crosses into a new page, the row is closed and then reopened. A periodic tick from an external interval timer requests a column-before-row refresh cycle, which the block runs between accesses.

Top module: `dram_page_sequencer`

## Requirements
- R1: While `cfg_enable` is 0, `ras_n`, `cas_n` and `we_n` stay 1, `core_ack` and `dma_valid` stay 0, and requests presented in that time are not served later.
- R2: After reset, and while enabled and idle with `cfg_self_refresh` = 0, all three strobes are 1 and no acknowledge is given.
- R3: A single-word access holds `ras_n` low for one clock with the row on `dram_addr`, then drives `cas_n` low for one clock with the column on `dram_addr` while `core_ack` (or `dma_valid`) is 1, then raises both strobes for one precharge clock.
- R4: With `cfg_slow_mux` = 1, one extra clock with `ras_n` low and `cas_n` high is inserted before the column clock of every single-word access and of the first burst word only.
- R5: With `cfg_edo` = 0, each burst word after the first that stays in the same page follows the previous word by `cfg_burst_sel` + 2 clocks (code 0..3 gives 2..5 clocks).
- R6: With `cfg_edo` = 1, each burst word after the first that stays in the same page follows the previous word by exactly 1 clock, whatever `cfg_burst_sel` holds.
- R7: `cfg_page_sel` codes 0, 1, 2 and 3 select pages of 256, 512, 1024 and 2048 words. The column is the low 8 + code bits of the word address and the row is the remaining upper bits.
- R8: When the next burst word starts a new page, `ras_n` rises for one clock and a full row phase follows, without the slow-multiplex clock. The next word then comes 3 clocks after the previous one.
- R9: A `refresh_tick` pulse causes one clock with `cas_n` low and `ras_n` high, then two clocks with both low, then both high. A pending refresh is served before a waiting request but never splits an access or a burst.
- R10: When both request inputs are sampled together in idle, the burst is served first and the single-word request waits until the burst has finished.
- R11: With `cfg_self_refresh` = 1, the idle controller holds `ras_n` and `cas_n` low. A request makes it raise both strobes for two clocks before the row phase, and it returns to holding both low once idle again.
- R12: `we_n` is 0 only during the column clock of a single-word write (`core_we` = 1) and is 1 for every read and burst.
- R13: `dma_last` is 1 only together with the `dma_valid` of the final burst word, and a length of 0 is served as one word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_enable | input | 1 | Master enable for the sequencer |
| cfg_self_refresh | input | 1 | 0: refresh by tick only; 1: hold self-refresh while idle |
| cfg_burst_sel | input | 2 | Clocks per later fast-page burst word, minus 2 |
| cfg_edo | input | 1 | One-clock later burst words |
| cfg_page_sel | input | 2 | Page length code (256 << code words) |
| cfg_slow_mux | input | 1 | Extra clock between row and column phase |
| refresh_tick | input | 1 | One-clock refresh request from the interval timer |
| core_req | input | 1 | Single-word request, held until `core_ack` |
| core_we | input | 1 | Single-word request is a write |
| core_addr | input | AW | Single-word word address |
| dma_req | input | 1 | Burst request, sampled when idle |
| dma_addr | input | AW | First word address of the burst |
| dma_len | input | LW | Number of words in the burst |
| core_ack | output | 1 | Single-word access completes this clock |
| dma_valid | output | 1 | Burst word transferred this clock |
| dma_last | output | 1 | This burst word is the final one |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write strobe, active low |
| dram_addr | output | AW-8 | Multiplexed row/column address |

## Verification
The checker assumes that configuration inputs change only while the controller is idle. It also assumes that the enable input is not lowered in the middle of a refresh, and that a burst request is withdrawn before its burst ends so that it is not taken twice. The bench changes configuration only after the previous access has fully drained. It pulses `dma_req` for a single clock and holds `core_req` until its acknowledge. Every tick is issued while the block is enabled, and its expected timing is computed relative to whether the block is idle or in a burst.

// File: rtl/dram_seq_pkg.sv
// Shared types for the page-mode DRAM sequencer.
// Assumes nothing beyond being compiled before the modules that import it.
package dram_seq_pkg;

    // Controller phases; each value maps to one fixed strobe pattern.
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ROW,
        ST_MUXW,
        ST_COL,
        ST_GAP,
        ST_PRE,
        ST_REFC,
        ST_REFB,
        ST_SELF,
        ST_SREXIT
    } seq_state_e;

endpackage

// File: rtl/dram_addr_split.sv
// Splits a word address into row and column parts for the selected page
// length and flags the last word of a page.
// Assumes AW - COL_MIN >= COL_MIN + 3 so the widest column fits the bus.
module dram_addr_split #(
    parameter int AW      = 22,
    parameter int COL_MIN = 8,
    localparam int MAW    = AW - COL_MIN
) (
    input  logic [AW-1:0]  addr,
    input  logic [1:0]     page_sel,
    output logic [MAW-1:0] row_addr,
    output logic [MAW-1:0] col_addr,
    output logic           page_last
);

    int unsigned     col_bits;
    logic [AW-1:0]   col_mask;

    // Derive the column width, then cut the address at that point.
    always_comb begin
        col_bits  = COL_MIN + int'(page_sel);
        col_mask  = (AW'(1) << col_bits) - AW'(1);
        row_addr  = MAW'(addr >> col_bits);
        col_addr  = MAW'(addr & col_mask);
        page_last = ((addr & col_mask) == col_mask);
    end

endmodule

// File: rtl/dram_refresh_req.sv
// Holds one pending refresh request raised by the interval tick until the
// controller starts a refresh or enters self-refresh.
// Assumes ticks are far apart compared with one refresh cycle.
module dram_refresh_req (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic take,
    input  logic flush,
    output logic pending
);

    // A new tick wins over a same-cycle take so no request is lost.
    always_ff @(posedge clk) begin
        if (!rst_n) pending <= 1'b0;
        else        pending <= (pending && !take && !flush) || tick;
    end

endmodule

// File: rtl/dram_seq_ctrl.sv
// Phase controller: arbitrates refresh, burst and single-word requests,
// steps through row, column, gap and precharge phases and decodes strobes.
// Assumes configuration is stable while not idle and that dma_req is
// dropped before its burst completes.
module dram_seq_ctrl
    import dram_seq_pkg::*;
#(
    parameter int AW   = 22,
    parameter int LW   = 8,
    parameter int MAW  = 14
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           enable,
    input  logic           self_mode,
    input  logic [1:0]     burst_sel,
    input  logic           edo,
    input  logic           slow_mux,
    input  logic           ref_pend,
    input  logic           dma_req,
    input  logic [AW-1:0]  dma_addr,
    input  logic [LW-1:0]  dma_len,
    input  logic           core_req,
    input  logic           core_we,
    input  logic [AW-1:0]  core_addr,
    input  logic [MAW-1:0] row_addr,
    input  logic [MAW-1:0] col_addr,
    input  logic           page_last,
    output logic           ref_take,
    output logic           ref_flush,
    output logic [AW-1:0]  cur_addr,
    output logic           ras_n,
    output logic           cas_n,
    output logic           we_n,
    output logic [MAW-1:0] dram_addr,
    output logic           core_ack,
    output logic           dma_valid,
    output logic           dma_last
);

    seq_state_e    state;
    logic [LW-1:0] words_left;
    logic          is_dma;
    logic          is_write;
    logic          first_word;
    logic          reopen;
    logic [2:0]    wait_cnt;
    logic          ras_low;
    logic          cas_low;

    // Phase sequencing; disabling returns everything to idle at once.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            state      <= ST_IDLE;
            cur_addr   <= '0;
            words_left <= '0;
            is_dma     <= 1'b0;
            is_write   <= 1'b0;
            first_word <= 1'b0;
            reopen     <= 1'b0;
            wait_cnt   <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (ref_pend) begin
                        state <= ST_REFC;
                    end else if (dma_req) begin
                        cur_addr   <= dma_addr;
                        words_left <= dma_len;
                        is_dma     <= 1'b1;
                        is_write   <= 1'b0;
                        first_word <= 1'b1;
                        state      <= ST_ROW;
                    end else if (core_req) begin
                        cur_addr   <= core_addr;
                        words_left <= LW'(1);
                        is_dma     <= 1'b0;
                        is_write   <= core_we;
                        first_word <= 1'b1;
                        state      <= ST_ROW;
                    end else if (self_mode) begin
                        state <= ST_SELF;
                    end
                end
                ST_ROW:  state <= (slow_mux && first_word) ? ST_MUXW : ST_COL;
                ST_MUXW: state <= ST_COL;
                ST_COL: begin
                    first_word <= 1'b0;
                    if (is_dma && words_left > LW'(1)) begin
                        words_left <= words_left - LW'(1);
                        cur_addr   <= cur_addr + AW'(1);
                        if (page_last) begin
                            reopen <= 1'b1;
                            state  <= ST_PRE;
                        end else if (edo) begin
                            state <= ST_COL;
                        end else begin
                            wait_cnt <= {1'b0, burst_sel};
                            state    <= ST_GAP;
                        end
                    end else begin
                        reopen <= 1'b0;
                        state  <= ST_PRE;
                    end
                end
                ST_GAP: begin
                    if (wait_cnt == 3'd0) state <= ST_COL;
                    else                  wait_cnt <= wait_cnt - 3'd1;
                end
                ST_PRE: begin
                    reopen <= 1'b0;
                    state  <= reopen ? ST_ROW : ST_IDLE;
                end
                ST_REFC: begin
                    wait_cnt <= 3'd1;
                    state    <= ST_REFB;
                end
                ST_REFB: begin
                    if (wait_cnt == 3'd0) state <= ST_IDLE;
                    else                  wait_cnt <= wait_cnt - 3'd1;
                end
                ST_SELF: begin
                    if (!self_mode || dma_req || core_req) state <= ST_SREXIT;
                end
                ST_SREXIT: state <= ST_IDLE;
                default:   state <= ST_IDLE;
            endcase
        end
    end

    // Refresh bookkeeping handshakes with the pending-request flag.
    always_comb begin
        ref_take  = enable && (state == ST_IDLE) && ref_pend;
        ref_flush = (state == ST_SELF);
    end

    // Strobe, address and acknowledge decode from the current phase.
    always_comb begin
        ras_low   = state inside {ST_ROW, ST_MUXW, ST_COL, ST_GAP, ST_REFB, ST_SELF};
        cas_low   = state inside {ST_COL, ST_REFC, ST_REFB, ST_SELF};
        ras_n     = !(enable && ras_low);
        cas_n     = !(enable && cas_low);
        core_ack  = enable && (state == ST_COL) && !is_dma;
        dma_valid = enable && (state == ST_COL) && is_dma;
        dma_last  = dma_valid && (words_left <= LW'(1));
        we_n      = !(core_ack && is_write);
        case (state)
            ST_ROW:                  dram_addr = row_addr;
            ST_MUXW, ST_COL, ST_GAP: dram_addr = col_addr;
            default:                 dram_addr = '0;
        endcase
    end

endmodule

// File: rtl/dram_page_sequencer.sv
// Top level of the page-mode DRAM sequencer: connects the refresh request
// flag, the phase controller and the row/column address splitter.
// Assumes static configuration and requesters that follow the handshakes
// described in the brief.
module dram_page_sequencer #(
    parameter int AW      = 22,
    parameter int LW      = 8,
    parameter int COL_MIN = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_enable,
    input  logic                  cfg_self_refresh,
    input  logic [1:0]            cfg_burst_sel,
    input  logic                  cfg_edo,
    input  logic [1:0]            cfg_page_sel,
    input  logic                  cfg_slow_mux,
    input  logic                  refresh_tick,
    input  logic                  core_req,
    input  logic                  core_we,
    input  logic [AW-1:0]         core_addr,
    input  logic                  dma_req,
    input  logic [AW-1:0]         dma_addr,
    input  logic [LW-1:0]         dma_len,
    output logic                  core_ack,
    output logic                  dma_valid,
    output logic                  dma_last,
    output logic                  ras_n,
    output logic                  cas_n,
    output logic                  we_n,
    output logic [AW-COL_MIN-1:0] dram_addr
);

    localparam int MAW = AW - COL_MIN;

    logic           ref_pend;
    logic           ref_take;
    logic           ref_flush;
    logic [AW-1:0]  cur_addr;
    logic [MAW-1:0] row_addr;
    logic [MAW-1:0] col_addr;
    logic           page_last;

    dram_refresh_req u_ref (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (refresh_tick),
        .take    (ref_take),
        .flush   (ref_flush),
        .pending (ref_pend)
    );

    dram_addr_split #(.AW(AW), .COL_MIN(COL_MIN)) u_split (
        .addr      (cur_addr),
        .page_sel  (cfg_page_sel),
        .row_addr  (row_addr),
        .col_addr  (col_addr),
        .page_last (page_last)
    );

    dram_seq_ctrl #(.AW(AW), .LW(LW), .MAW(MAW)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (cfg_enable),
        .self_mode (cfg_self_refresh),
        .burst_sel (cfg_burst_sel),
        .edo       (cfg_edo),
        .slow_mux  (cfg_slow_mux),
        .ref_pend  (ref_pend),
        .dma_req   (dma_req),
        .dma_addr  (dma_addr),
        .dma_len   (dma_len),
        .core_req  (core_req),
        .core_we   (core_we),
        .core_addr (core_addr),
        .row_addr  (row_addr),
        .col_addr  (col_addr),
        .page_last (page_last),
        .ref_take  (ref_take),
        .ref_flush (ref_flush),
        .cur_addr  (cur_addr),
        .ras_n     (ras_n),
        .cas_n     (cas_n),
        .we_n      (we_n),
        .dram_addr (dram_addr),
        .core_ack  (core_ack),
        .dma_valid (dma_valid),
        .dma_last  (dma_last)
    );

endmodule

// File: rtl/dram_page_sequencer_chk.sv
// Protocol checker for the page-mode DRAM sequencer, bound to the top.
// Assumes configuration only changes while idle and enable is not dropped
// mid-refresh.
module dram_page_sequencer_chk (
    input logic clk,
    input logic rst_n,
    input logic cfg_enable,
    input logic ras_n,
    input logic cas_n,
    input logic we_n,
    input logic core_ack,
    input logic dma_valid,
    input logic dma_last
);

    // R1: a disabled controller is silent on every strobe and handshake.
    assert_disabled_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_enable |-> (ras_n && cas_n && we_n && !core_ack && !dma_valid));

    // R3: a transfer clock has both strobes low and the row opened earlier.
    assert_ras_leads_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (core_ack || dma_valid) |-> (!ras_n && !cas_n && $past(!ras_n)));

    // R9: column-first refresh runs its fixed strobe order to completion.
    assert_refresh_order_R9: assert property (@(posedge clk) disable iff (!rst_n || !cfg_enable)
        (!cas_n && ras_n) |=> (!cas_n && !ras_n) ##1 (!cas_n && !ras_n) ##1 (cas_n && ras_n));

    // R10: at most one requester is served in any clock.
    assert_one_grant_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(core_ack && dma_valid));

    // R12: the write strobe only appears inside an open column phase.
    assert_we_in_column_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> (!cas_n && !ras_n && core_ack));

    // R13: the final-word flag never appears without a burst word.
    assert_last_with_word_R13: assert property (@(posedge clk) disable iff (!rst_n)
        dma_last |-> dma_valid);

endmodule

bind dram_page_sequencer dram_page_sequencer_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_enable (cfg_enable),
    .ras_n      (ras_n),
    .cas_n      (cas_n),
    .we_n       (we_n),
    .core_ack   (core_ack),
    .dma_valid  (dma_valid),
    .dma_last   (dma_last)
);

// File: tb/dram_page_sequencer_bench.sv
module dram_page_sequencer_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_enable = 1'b0;
    logic        cfg_self_refresh = 1'b0;
    logic [1:0]  cfg_burst_sel = '0;
    logic        cfg_edo = 1'b0;
    logic [1:0]  cfg_page_sel = '0;
    logic        cfg_slow_mux = 1'b0;
    logic        refresh_tick = 1'b0;
    logic        core_req = 1'b0;
    logic        core_we = 1'b0;
    logic [21:0] core_addr = '0;
    logic        dma_req = 1'b0;
    logic [21:0] dma_addr = '0;
    logic [7:0]  dma_len = '0;
    logic        core_ack, dma_valid, dma_last, ras_n, cas_n, we_n;
    logic [13:0] dram_addr;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    dram_page_sequencer u_dram_page_sequencer (.*);

    typedef struct packed {
        logic        dma;
        logic        we;
        logic [21:0] addr;
        logic [7:0]  len;
        logic [1:0]  bs;
        logic        edo;
        logic [1:0]  ps;
        logic        slow;
        logic [3:0]  lat;
        logic [3:0]  sp12;
        logic [3:0]  sp23;
        logic [3:0]  nval;
        logic [3:0]  nras;
        logic [13:0] row;
        logic [13:0] col;
    } vec_t;

    localparam vec_t VECS [0:8] = '{
        '{1'b0, 1'b0, 22'h012345, 8'd1, 2'd0, 1'b0, 2'd0, 1'b0, 4'd1, 4'd0, 4'd0, 4'd1, 4'd1, 14'h0123, 14'h045},
        '{1'b0, 1'b1, 22'h3ABCDE, 8'd1, 2'd0, 1'b0, 2'd3, 1'b1, 4'd2, 4'd0, 4'd0, 4'd1, 4'd1, 14'h0757, 14'h4DE},
        '{1'b1, 1'b0, 22'h000100, 8'd4, 2'd0, 1'b0, 2'd0, 1'b0, 4'd1, 4'd2, 4'd2, 4'd4, 4'd1, 14'h0001, 14'h000},
        '{1'b1, 1'b0, 22'h000200, 8'd3, 2'd3, 1'b0, 2'd1, 1'b1, 4'd2, 4'd5, 4'd5, 4'd3, 4'd1, 14'h0001, 14'h000},
        '{1'b1, 1'b0, 22'h000010, 8'd4, 2'd3, 1'b1, 2'd2, 1'b0, 4'd1, 4'd1, 4'd1, 4'd4, 4'd1, 14'h0000, 14'h010},
        '{1'b1, 1'b0, 22'h0001FE, 8'd4, 2'd2, 1'b0, 2'd0, 1'b1, 4'd2, 4'd4, 4'd3, 4'd4, 4'd2, 14'h0001, 14'h0FE},
        '{1'b1, 1'b0, 22'h0003FF, 8'd3, 2'd0, 1'b1, 2'd1, 1'b1, 4'd2, 4'd3, 4'd1, 4'd3, 4'd2, 14'h0001, 14'h1FF},
        '{1'b1, 1'b0, 22'h155555, 8'd1, 2'd3, 1'b0, 2'd0, 1'b0, 4'd1, 4'd0, 4'd0, 4'd1, 4'd1, 14'h1555, 14'h055},
        '{1'b1, 1'b0, 22'h000042, 8'd0, 2'd1, 1'b0, 2'd0, 1'b0, 4'd1, 4'd0, 4'd0, 4'd1, 4'd1, 14'h0000, 14'h042}
    };

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic run_vec(input vec_t v);
        int t0 = -1, nv = 0, nr = 0, nwe = 0, nlast = 0, lastflag = 0;
        int tv [0:7];
        logic prev_ras = 1'b1;
        logic [13:0] row_s = '0, col_s = '0;
        string st;
        foreach (tv[i]) tv[i] = 0;
        @(negedge clk);
        cfg_burst_sel = v.bs; cfg_edo = v.edo; cfg_page_sel = v.ps; cfg_slow_mux = v.slow;
        @(negedge clk);
        if (v.dma) begin dma_req = 1'b1; dma_addr = v.addr; dma_len = v.len; end
        else       begin core_req = 1'b1; core_we = v.we; core_addr = v.addr; end
        @(negedge clk);
        dma_req = 1'b0; core_req = 1'b0;
        for (int c = 0; c < 60; c++) begin
            if (c > 0) @(negedge clk);
            if (!ras_n && t0 < 0) begin t0 = c; row_s = dram_addr; end
            if (core_ack || dma_valid) begin
                if (nv < 8) tv[nv] = c;
                if (nv == 0) col_s = dram_addr;
                nv++;
                lastflag = int'(dma_last);
            end
            if (dma_last) nlast++;
            if (!we_n) nwe++;
            if (!prev_ras && ras_n) nr++;
            prev_ras = ras_n;
        end
        check(v.slow ? "R4 first-word latency" : "R3 first-word latency", tv[0] - t0, int'(v.lat));
        st = (v.nras > 1) ? "R8 spacing across page" : (v.edo ? "R6 edo spacing" : "R5 page spacing");
        check(st, (nv > 1) ? tv[1] - tv[0] : 0, int'(v.sp12));
        check(st, (nv > 2) ? tv[2] - tv[1] : 0, int'(v.sp23));
        check("R13 word count", nv, int'(v.nval));
        check("R8 row openings", nr, int'(v.nras));
        check("R7 row address", int'(row_s), int'(v.row));
        check("R7 column address", int'(col_s), int'(v.col));
        check("R12 write strobe clocks", nwe, (!v.dma && v.we) ? 1 : 0);
        if (v.dma) begin
            check("R13 last flag count", nlast, 1);
            check("R13 last on final word", lastflag, 1);
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        int act, t_ref, t_last, nv;
        int tv [0:3];
        logic [11:0] pat;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R2: reset state
        check("R2 reset strobes", int'({ras_n, cas_n, we_n}), 7);
        check("R2 reset acks", int'({core_ack, dma_valid}), 0);

        // R1: requests while disabled are ignored and forgotten
        act = 0;
        core_req = 1'b1; dma_req = 1'b1; dma_len = 8'd2;
        for (int c = 0; c < 6; c++) begin
            @(negedge clk);
            if (!ras_n || !cas_n || !we_n || core_ack || dma_valid) act++;
        end
        core_req = 1'b0; dma_req = 1'b0;
        check("R1 disabled activity", act, 0);
        cfg_enable = 1'b1;
        act = 0;
        for (int c = 0; c < 6; c++) begin
            @(negedge clk);
            if (!ras_n || !cas_n || core_ack || dma_valid) act++;
        end
        check("R1 no late service", act, 0);
        check("R2 enabled idle strobes", int'({ras_n, cas_n, we_n}), 7);

        // Vector table: R3 R4 R5 R6 R7 R8 R12 R13
        foreach (VECS[i]) run_vec(VECS[i]);

        // R9: refresh strobe order from idle
        @(negedge clk); refresh_tick = 1'b1;
        @(negedge clk); refresh_tick = 1'b0;
        pat = '0;
        for (int c = 0; c < 6; c++) begin
            if (c > 0) @(negedge clk);
            pat = {pat[9:0], ras_n, cas_n};
        end
        check("R9 refresh pattern", int'(pat), int'(12'b11_10_00_00_11_11));

        // R9: pending refresh served before a waiting request
        repeat (3) @(negedge clk);
        refresh_tick = 1'b1;
        @(negedge clk); refresh_tick = 1'b0;
        core_req = 1'b1; core_we = 1'b0; core_addr = 22'h000777;
        act = -1;
        for (int c = 0; c < 20; c++) begin
            @(negedge clk);
            if (act < 0 && (!ras_n || !cas_n)) act = int'({ras_n, cas_n});
            if (core_ack) begin core_req = 1'b0; act = (act == 2) ? 100 : act; end
        end
        core_req = 1'b0;
        check("R9 refresh before access then ack", act, 100);

        // R9: a tick during a burst does not split it
        cfg_burst_sel = 2'd3; cfg_edo = 1'b0; cfg_slow_mux = 1'b0; cfg_page_sel = 2'd0;
        @(negedge clk);
        dma_req = 1'b1; dma_addr = 22'h000020; dma_len = 8'd3;
        @(negedge clk); dma_req = 1'b0;
        nv = 0; t_ref = -1; t_last = -1;
        foreach (tv[i]) tv[i] = 0;
        for (int c = 0; c < 40; c++) begin
            if (c > 0) @(negedge clk);
            refresh_tick = 1'b0;
            if (dma_valid) begin
                if (nv < 4) tv[nv] = c;
                if (nv == 0) refresh_tick = 1'b1;
                nv++; t_last = c;
            end
            if (t_ref < 0 && !cas_n && ras_n) t_ref = c;
        end
        refresh_tick = 1'b0;
        check("R9 burst spacing kept 1-2", tv[1] - tv[0], 5);
        check("R9 burst spacing kept 2-3", tv[2] - tv[1], 5);
        check("R9 refresh after burst", (t_ref > t_last) ? 1 : 0, 1);

        // R10: burst wins over a simultaneous single-word request
        @(negedge clk);
        cfg_burst_sel = 2'd0;
        core_req = 1'b1; core_addr = 22'h000300;
        dma_req = 1'b1; dma_addr = 22'h000400; dma_len = 8'd2;
        @(negedge clk); dma_req = 1'b0;
        act = 0; nv = 0;
        for (int c = 0; c < 20; c++) begin
            if (c > 0) @(negedge clk);
            if (dma_valid) nv++;
            if (core_ack) begin act = (nv == 2) ? 1 : 2; core_req = 1'b0; end
        end
        core_req = 1'b0;
        check("R10 core served after whole burst", act, 1);

        // R11: self-refresh hold, exit and re-entry
        cfg_self_refresh = 1'b1;
        repeat (4) @(negedge clk);
        check("R11 idle self-refresh strobes", int'({ras_n, cas_n}), 0);
        core_req = 1'b1; core_we = 1'b1; core_addr = 22'h000055;
        pat = '0; act = 0;
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            if (c < 3) pat = {pat[9:0], ras_n, cas_n};
            if (core_ack) begin act = 1; core_req = 1'b0; end
        end
        core_req = 1'b0;
        check("R11 exit pattern", int'(pat[5:0]), int'(6'b11_11_01));
        check("R11 access acknowledged", act, 1);
        repeat (4) @(negedge clk);
        check("R11 re-entered self-refresh", int'({ras_n, cas_n}), 0);
        cfg_self_refresh = 1'b0;
        repeat (3) @(negedge clk);
        check("R11 left self-refresh", int'({ras_n, cas_n}), 3);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule